// File: doc/BRIEF.md
# Hot-Plug Slot Control and Status Registers

This block holds the slot control and slot status registers of a hot-plug capable downstream or root port. Software reaches both through one 32-bit configuration write port: slot control sits in byte lanes 0 and 1, slot status in byte lanes 2 and 3, and the read port always returns `{status, control}`. The slot side drives four event strobes into the block: card insertion, attention button press, presence change and an unplug request. The block decides when the host must be told about an event. It also drives a one-bit interlock, a presence-state output and a detach strobe towards the slot.

Whether the host is told depends on a single "notified" condition. That condition is true when the hot-plug interrupt enable is set and at least one of the three event status bits is set together with its matching enable. A small state machine tracks this condition in two states. `NOTE_IDLE` means not notified. `NOTE_RAISED` means notified. The *raise* transition goes from idle to raised, and the *drop* transition goes from raised to idle. An interrupt is produced only on a transition. In message mode each transition gives a one-cycle pulse. In level mode the line follows the state.

Every write that reaches slot control counts as a command. The command completes in the same cycle and sets the command-completed status bit. Each write is applied at the clock edge, and its effects are visible on the read port and the interrupt outputs just after that edge.

Top module: `hp_slot_regs`

Control layout: bit 0 button event enable, bit 1 presence-change event enable, bit 2 command-completed event enable, bit 3 hot-plug interrupt enable, bits 5:4 attention indicator, bits 7:6 power indicator, bit 8 power controller control (1 = power off), bit 9 interlock toggle command. The indicator encoding is 01 on, 10 blink, 11 off. Status layout: bit 0 button pressed, bit 1 presence changed, bit 2 command completed, bit 3 presence state, bit 4 interlock engaged.

## Requirements
- R1: With `slot_occupied_i`=1 during reset, the port reads `0x0008_0070`, and `intx_o`, `msi_pulse_o` and `detach_o` are 0.
- R2: A control write changes only the control bits 8:0, and only in byte lanes whose enable is set; bits 15:10 always read 0.
- R3: A control write with lane 1 enabled and data bit 9 set toggles status bit 4 (interlock); control bit 9 always reads 0.
- R4: Any write with `cfg_be_i[1:0]` nonzero sets status bit 2 (command completed), even when no field changes; a write with no byte enables changes nothing.
- R5: Writing one to status bits 2:0 in lane 2 clears them; status bits 4:3 ignore status writes.
- R6: The notified condition is control bit 3 AND the OR over bits 2:0 of (status AND control).
- R7: With `msi_en_i`=1, `msi_pulse_o` is high for exactly one cycle after each raise or drop transition, and `intx_o` does not change.
- R8: With `msi_en_i`=0, `intx_o` follows the notified condition, and it falls after a status write that leaves the condition false.
- R9: Setting an event bit that is already set produces no new pulse and no change on `intx_o`.
- R10: A control write issues a detach when all three of these hold: presence state is 1, the written control bit 8 is 1, and the written power indicator is 11. The detach raises `detach_o` for one cycle, clears status bit 3 and sets status bit 1. A byte lane that is not enabled contributes its current value.
- R11: `card_insert_i` sets status bits 3, 1 and 0. `btn_press_i` and `unplug_req_i` set bit 0 only. `presence_chg_i` sets bit 1 only. An event wins over a write-one-to-clear in the same cycle. `slot_present_o` mirrors status bit 3.
- R12: While the interlock is engaged, `card_insert_i` and `unplug_req_i` are ignored.
- R13: With `slot_occupied_i`=0 during reset, the port reads `0x0000_01F0`, and `slot_present_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_occupied_i | input | 1 | Slot occupancy, sampled during reset |
| msi_en_i | input | 1 | Message interrupt mode selected |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_be_i | input | 4 | Byte enables: lanes 1:0 control, lanes 3:2 status |
| cfg_wdata_i | input | 32 | Write data `{status, control}` |
| cfg_rdata_o | output | 32 | Read data `{status, control}` |
| btn_press_i | input | 1 | Attention button event |
| card_insert_i | input | 1 | Card inserted event |
| presence_chg_i | input | 1 | Presence change event |
| unplug_req_i | input | 1 | Unplug request, reported as a button event |
| msi_pulse_o | output | 1 | One-cycle message interrupt request |
| intx_o | output | 1 | Level interrupt line |
| detach_o | output | 1 | One-cycle detach strobe to the slot |
| slot_present_o | output | 1 | Presence state |

## Verification
Two situations are hard to reach. The first is an interrupt edge that comes only from a control write: nothing new is set in status, yet the write sets command-completed, which meets an enable that was already set and raises the interrupt. The second is a detach driven by a single-lane write, where the indicator field comes from the stored value and not from the write data. The stimulus table reaches both by setting up enables and the "off" indicator in earlier vectors, and then issuing partial-lane writes. The same table also engages the interlock and offers an insertion while it is engaged.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
    localparam int REG_W   = 16;
    localparam int LANE_W  = 8;
    localparam int LANES   = REG_W / LANE_W;
    localparam int EV_BITS = 3;

    // control bit positions
    localparam int C_CC_EN  = 2;
    localparam int C_HPIE   = 3;
    localparam int C_PWRCTL = 8;
    localparam int C_LOCK   = 9;

    // status bit positions
    localparam int S_BTN  = 0;
    localparam int S_PDC  = 1;
    localparam int S_CC   = 2;
    localparam int S_PRES = 3;
    localparam int S_LOCK = 4;

    localparam logic [1:0] IND_ON  = 2'b01;
    localparam logic [1:0] IND_OFF = 2'b11;

    typedef enum logic {
        NOTE_IDLE   = 1'b0,
        NOTE_RAISED = 1'b1
    } note_state_e;
endpackage

// File: rtl/hp_slot_ctl.sv
module hp_slot_ctl
    import hp_slot_pkg::*;
#(
    parameter bit HAS_PWR_CTL = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     occupied_i,
    input  logic                     touch_i,
    input  logic [LANES-1:0]         be_i,
    input  logic [REG_W-1:0]         wdata_i,
    input  logic                     present_i,
    output logic [REG_W-1:0]         ctl_q_o,
    output logic [REG_W-1:0]         ctl_n_o,
    output logic                     lock_toggle_o,
    output logic                     detach_o
);
    localparam logic [REG_W-1:0] WMASK =
        HAS_PWR_CTL ? 16'h01FF : 16'h00FF;

    logic [REG_W-1:0] ctl_q;
    logic [REG_W-1:0] view;
    logic [REG_W-1:0] rst_val;

    // merged view of the write: enabled lanes from data, others from register
    always_comb begin
        view = ctl_q;
        for (int b = 0; b < LANES; b++) begin
            if (touch_i && be_i[b]) begin
                view[b*LANE_W +: LANE_W] = wdata_i[b*LANE_W +: LANE_W];
            end
        end
    end

    assign ctl_n_o       = view & WMASK;
    assign lock_toggle_o = touch_i && be_i[C_LOCK/LANE_W] && wdata_i[C_LOCK];
    assign detach_o      = touch_i && present_i && view[C_PWRCTL] &&
                           (view[7:6] == IND_OFF);

    always_comb begin
        rst_val      = '0;
        rst_val[5:4] = IND_OFF;
        if (HAS_PWR_CTL) begin
            rst_val[C_PWRCTL] = !occupied_i;
            rst_val[7:6]      = occupied_i ? IND_ON : IND_OFF;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= rst_val;
        else        ctl_q <= ctl_n_o;
    end

    assign ctl_q_o = ctl_q;

    // R2: bits above the writable field never become set
    a_r2_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        touch_i |=> (ctl_q[REG_W-1:C_LOCK] == '0));
endmodule

// File: rtl/hp_slot_sts.sv
module hp_slot_sts
    import hp_slot_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                occupied_i,
    input  logic                ctl_touch_i,
    input  logic                sts_touch_i,
    input  logic                sts_lane_i,
    input  logic [LANE_W-1:0]   sts_wdata_i,
    input  logic                lock_toggle_i,
    input  logic                detach_i,
    input  logic                btn_i,
    input  logic                insert_i,
    input  logic                pchg_i,
    input  logic                unplug_i,
    output logic [REG_W-1:0]    sts_q_o,
    output logic [REG_W-1:0]    sts_n_o,
    output logic                detach_o
);
    logic [REG_W-1:0] sts_q;
    logic [REG_W-1:0] sts_n;
    logic             det_q;
    logic             locked;

    assign locked = sts_q[S_LOCK];

    always_comb begin
        sts_n = sts_q;
        if (sts_touch_i && sts_lane_i) begin
            for (int i = 0; i < EV_BITS; i++) begin
                if (sts_wdata_i[i]) sts_n[i] = 1'b0;
            end
        end
        if (lock_toggle_i) sts_n[S_LOCK] = !sts_q[S_LOCK];
        if (detach_i) begin
            sts_n[S_PRES] = 1'b0;
            sts_n[S_PDC]  = 1'b1;
        end
        if (!locked && insert_i) begin
            sts_n[S_PRES] = 1'b1;
            sts_n[S_PDC]  = 1'b1;
            sts_n[S_BTN]  = 1'b1;
        end
        if (!locked && unplug_i) sts_n[S_BTN] = 1'b1;
        if (btn_i)               sts_n[S_BTN] = 1'b1;
        if (pchg_i)              sts_n[S_PDC] = 1'b1;
        if (ctl_touch_i)         sts_n[S_CC]  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q         <= '0;
            sts_q[S_PRES] <= occupied_i;
            det_q         <= 1'b0;
        end else begin
            sts_q <= sts_n;
            det_q <= detach_i;
        end
    end

    assign sts_q_o  = sts_q;
    assign sts_n_o  = sts_n;
    assign detach_o = det_q;

    // R3: an interlock command flips the interlock status
    a_r3_lock_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        lock_toggle_i |=> (sts_q[S_LOCK] != $past(sts_q[S_LOCK])));
    // R4: a control write leaves command completed set
    a_r4_cmd_done: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_touch_i |=> sts_q[S_CC]);
    // R10: a detach strobe comes with presence changed
    a_r10_detach_pdc: assert property (@(posedge clk) disable iff (!rst_n)
        det_q |-> sts_q[S_PDC]);
endmodule

// File: rtl/hp_slot_notify.sv
module hp_slot_notify
    import hp_slot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic notified_n_i,
    input  logic msi_en_i,
    input  logic sts_touch_i,
    output logic msi_pulse_o,
    output logic intx_o
);
    note_state_e state_q, state_n;
    logic        moving;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            NOTE_IDLE:   if (notified_n_i)  state_n = NOTE_RAISED; // raise
            NOTE_RAISED: if (!notified_n_i) state_n = NOTE_IDLE;   // drop
            default:     state_n = NOTE_IDLE;
        endcase
    end

    assign moving = (state_n != state_q);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= NOTE_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msi_pulse_o <= 1'b0;
            intx_o      <= 1'b0;
        end else begin
            msi_pulse_o <= msi_en_i && moving;
            if (!msi_en_i && (moving || (sts_touch_i && state_n == NOTE_IDLE))) begin
                intx_o <= (state_n == NOTE_RAISED);
            end
        end
    end

    // R7: a pulse only follows a state transition
    a_r7_pulse_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        msi_pulse_o |-> (state_q != $past(state_q)));
    // R8: in level mode a transition leaves the line equal to the state
    a_r8_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!msi_en_i) && state_q != $past(state_q)) |->
            (intx_o == (state_q == NOTE_RAISED)));
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
    import hp_slot_pkg::*;
#(
    parameter bit HAS_PWR_CTL = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        slot_occupied_i,
    input  logic        msi_en_i,
    input  logic        cfg_wr_i,
    input  logic [3:0]  cfg_be_i,
    input  logic [31:0] cfg_wdata_i,
    output logic [31:0] cfg_rdata_o,
    input  logic        btn_press_i,
    input  logic        card_insert_i,
    input  logic        presence_chg_i,
    input  logic        unplug_req_i,
    output logic        msi_pulse_o,
    output logic        intx_o,
    output logic        detach_o,
    output logic        slot_present_o
);
    logic [REG_W-1:0] ctl_q, ctl_n, sts_q, sts_n;
    logic             ctl_touch, sts_touch, lock_toggle, detach_hit;
    logic             notified_n;

    assign ctl_touch = cfg_wr_i && (cfg_be_i[1:0] != 2'b00);
    assign sts_touch = cfg_wr_i && (cfg_be_i[3:2] != 2'b00);

    hp_slot_ctl #(.HAS_PWR_CTL(HAS_PWR_CTL)) u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .occupied_i    (slot_occupied_i),
        .touch_i       (ctl_touch),
        .be_i          (cfg_be_i[1:0]),
        .wdata_i       (cfg_wdata_i[15:0]),
        .present_i     (sts_q[S_PRES]),
        .ctl_q_o       (ctl_q),
        .ctl_n_o       (ctl_n),
        .lock_toggle_o (lock_toggle),
        .detach_o      (detach_hit)
    );

    hp_slot_sts u_sts (
        .clk           (clk),
        .rst_n         (rst_n),
        .occupied_i    (slot_occupied_i),
        .ctl_touch_i   (ctl_touch),
        .sts_touch_i   (sts_touch),
        .sts_lane_i    (cfg_be_i[2]),
        .sts_wdata_i   (cfg_wdata_i[23:16]),
        .lock_toggle_i (lock_toggle),
        .detach_i      (detach_hit),
        .btn_i         (btn_press_i),
        .insert_i      (card_insert_i),
        .pchg_i        (presence_chg_i),
        .unplug_i      (unplug_req_i),
        .sts_q_o       (sts_q),
        .sts_n_o       (sts_n),
        .detach_o      (detach_o)
    );

    // R6: notified condition over the next register values
    assign notified_n = ctl_n[C_HPIE] &&
                        ((sts_n[EV_BITS-1:0] & ctl_n[EV_BITS-1:0]) != '0);

    hp_slot_notify u_note (
        .clk          (clk),
        .rst_n        (rst_n),
        .notified_n_i (notified_n),
        .msi_en_i     (msi_en_i),
        .sts_touch_i  (sts_touch),
        .msi_pulse_o  (msi_pulse_o),
        .intx_o       (intx_o)
    );

    assign cfg_rdata_o    = {sts_q, ctl_q};
    assign slot_present_o = sts_q[S_PRES];

    // R6: in level mode with a steady mode bit, the line never disagrees with a settled condition
    a_r6_level_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (!msi_en_i && $past(!msi_en_i) && $past(!cfg_wr_i) && $stable(cfg_rdata_o)) |->
            (intx_o == (ctl_q[C_HPIE] && ((sts_q[2:0] & ctl_q[2:0]) != 3'b000))));
endmodule

// File: tb/sim_hp_slot_regs.sv
`timescale 1ns/1ps
module sim_hp_slot_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        occ = 1'b1;
    logic        msi = 1'b0;
    logic        wr = 1'b0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        btn = 1'b0, ins = 1'b0, pchg = 1'b0, unp = 1'b0;
    logic        msi_p, intx, det, pres;
    int          checks = 0;
    int          fails = 0;
    int          cyc = 0;

    always #2.5 clk = ~clk;

    hp_slot_regs u0 (
        .clk(clk), .rst_n(rst_n), .slot_occupied_i(occ), .msi_en_i(msi),
        .cfg_wr_i(wr), .cfg_be_i(be), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
        .btn_press_i(btn), .card_insert_i(ins), .presence_chg_i(pchg),
        .unplug_req_i(unp), .msi_pulse_o(msi_p), .intx_o(intx),
        .detach_o(det), .slot_present_o(pres)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        we;
        logic [3:0]  be;
        logic [31:0] wd;
        logic [3:0]  ev;     // {unplug, pchg, insert, btn}
        logic        msi;
        logic [31:0] rd;
        logic [2:0]  fl;     // {msi_pulse, intx, detach}
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        '{4'd1,  1'b0, 4'h0, 32'h0,         4'h0, 1'b0, 32'h0008_0070, 3'b000}, // R1 idle
        '{4'd2,  1'b1, 4'h3, 32'h0000_0008, 4'h0, 1'b0, 32'h000C_0008, 3'b000}, // R2 R4
        '{4'd6,  1'b1, 4'h3, 32'h0000_000C, 4'h0, 1'b0, 32'h000C_000C, 3'b010}, // R6 R8 raise by enable
        '{4'd9,  1'b1, 4'h3, 32'h0000_000C, 4'h0, 1'b0, 32'h000C_000C, 3'b010}, // R9 re-set CC
        '{4'd8,  1'b1, 4'hC, 32'h0004_0000, 4'h0, 1'b0, 32'h0008_000C, 3'b000}, // R8 clear drops line
        '{4'd6,  1'b0, 4'h0, 32'h0,         4'h1, 1'b0, 32'h0009_000C, 3'b000}, // R6 button not enabled
        '{4'd6,  1'b1, 4'h3, 32'h0000_000D, 4'h0, 1'b0, 32'h000D_000D, 3'b010}, // R6 enable button
        '{4'd5,  1'b1, 4'hC, 32'h0007_0000, 4'h0, 1'b0, 32'h0008_000D, 3'b000}, // R5 clear all events
        '{4'd7,  1'b0, 4'h0, 32'h0,         4'h1, 1'b1, 32'h0009_000D, 3'b100}, // R7 raise pulse
        '{4'd7,  1'b0, 4'h0, 32'h0,         4'h0, 1'b1, 32'h0009_000D, 3'b000}, // R7 single cycle
        '{4'd9,  1'b0, 4'h0, 32'h0,         4'h1, 1'b1, 32'h0009_000D, 3'b000}, // R9 no second pulse
        '{4'd7,  1'b1, 4'hC, 32'h0001_0000, 4'h0, 1'b1, 32'h0008_000D, 3'b100}, // R7 drop pulse
        '{4'd8,  1'b0, 4'h0, 32'h0,         4'h0, 1'b0, 32'h0008_000D, 3'b000}, // R8 back to level
        '{4'd3,  1'b1, 4'h3, 32'h0000_020D, 4'h0, 1'b0, 32'h001C_000D, 3'b010}, // R3 engage
        '{4'd12, 1'b0, 4'h0, 32'h0,         4'h2, 1'b0, 32'h001C_000D, 3'b010}, // R12 insert ignored
        '{4'd3,  1'b1, 4'h3, 32'h0000_020D, 4'h0, 1'b0, 32'h000C_000D, 3'b010}, // R3 release
        '{4'd5,  1'b1, 4'hC, 32'h001F_0000, 4'h0, 1'b0, 32'h0008_000D, 3'b000}, // R5 bits 4:3 kept
        '{4'd10, 1'b1, 4'h3, 32'h0000_01C0, 4'h0, 1'b0, 32'h0006_01C0, 3'b001}, // R10 detach
        '{4'd11, 1'b0, 4'h0, 32'h0,         4'h2, 1'b0, 32'h000F_01C0, 3'b000}, // R11 insert
        '{4'd10, 1'b1, 4'h2, 32'h0000_01C0, 4'h0, 1'b0, 32'h0007_01C0, 3'b001}, // R10 lane-1 only detach
        '{4'd2,  1'b1, 4'h1, 32'h0000_00FF, 4'h0, 1'b0, 32'h0007_01FF, 3'b010}, // R2 lane-0 only
        '{4'd5,  1'b1, 4'h4, 32'h0002_0000, 4'h0, 1'b0, 32'h0005_01FF, 3'b010}, // R5 clear PDC
        '{4'd11, 1'b0, 4'h0, 32'h0,         4'h4, 1'b0, 32'h0007_01FF, 3'b010}, // R11 presence change
        '{4'd5,  1'b1, 4'h4, 32'h0001_0000, 4'h0, 1'b0, 32'h0006_01FF, 3'b010}, // R5 clear ABP
        '{4'd11, 1'b0, 4'h0, 32'h0,         4'h8, 1'b0, 32'h0007_01FF, 3'b010}, // R11 unplug request
        '{4'd4,  1'b1, 4'h0, 32'hFFFF_FFFF, 4'h0, 1'b0, 32'h0007_01FF, 3'b010}, // R4 no lanes
        '{4'd2,  1'b1, 4'h3, 32'h0000_FC00, 4'h0, 1'b0, 32'h0007_0000, 3'b000}  // R2 reserved bits
    };

    task automatic chk(input string tag, input logic [34:0] act, input logic [34:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr = 1'b0; be = '0; wdata = '0;
        btn = 1'b0; ins = 1'b0; pchg = 1'b0; unp = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<5000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset occupied
        chk("R1", {rdata, msi_p, intx, det}, {32'h0008_0070, 3'b000});
        chk("R1 present", {34'b0, pres}, {34'b0, 1'b1});

        for (int i = 0; i < NV; i++) begin
            wr = VEC[i].we; be = VEC[i].be; wdata = VEC[i].wd;
            {unp, pchg, ins, btn} = VEC[i].ev;
            msi = VEC[i].msi;
            @(posedge clk);
            @(negedge clk);
            chk($sformatf("R%0d vec%0d", VEC[i].req, i),
                {rdata, msi_p, intx, det}, {VEC[i].rd, VEC[i].fl});
        end

        // R11: event beats a same-cycle clear
        idle_inputs();
        wr = 1'b1; be = 4'h4; wdata = 32'h0001_0000; btn = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R11 event wins", {rdata, msi_p, intx, det}, {32'h0007_0000, 3'b000});

        // R11: insert drives presence output
        idle_inputs();
        ins = 1'b1;
        @(posedge clk); @(negedge clk);
        idle_inputs();
        chk("R11 present", {34'b0, pres}, {34'b0, 1'b1});

        // R13: reset with empty slot
        rst_n = 1'b0; occ = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        chk("R13", {rdata, msi_p, intx, det}, {32'h0000_01F0, 3'b000});
        chk("R13 present", {34'b0, pres}, {34'b0, 1'b0});

        // R10: detach needs presence; empty slot gives none
        wr = 1'b1; be = 4'h3; wdata = 32'h0000_01C0;
        @(posedge clk); @(negedge clk);
        idle_inputs();
        chk("R10 empty no detach", {rdata, msi_p, intx, det}, {32'h0004_01C0, 3'b000});

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule